// File: doc/BRIEF.md
# Boot-Aware Reset Sequencer

This block produces the internal reset of a small microcontroller-style system. An active-low external reset pin and an active-low qualifier pin feed it. A reset is entered only when both pins are low. Each pin passes through a clock-domain synchroniser, and the reset pin also passes through a counting glitch filter whose length stands in for the analog filter delay.

While the system is held in reset, the block does the following:
- raises the core reset;
- drives the active-low reset indication low;
- cancels pending hold requests;
- puts the pin drivers into high impedance;
- enables a weak pull-up on the configuration port.

On entry to reset it also emits a single-cycle bus-abort pulse.

How reset is released depends on a boot strap. With external-memory boot, the core reset falls a programmable 3 to 8 clocks after the filtered pin rises. With internal-flash boot, the core reset is held until the embedded flash initialiser signals completion. From reset entry until flash initialisation finishes, a read override supplies placeholder data: 0xFFFF early in the initialisation window and 0x009B later.

Top module: `boot_reset_seq`

## Requirements
- R1: When the reset pin and the qualifier pin are both held low, core_rst rises right after the (FILT_N+3)-th rising edge, counting the first edge that samples both pins low.
- R2: A low reset pin while the qualifier pin is high never starts a reset; core_rst stays 0.
- R3: A reset-pin low pulse that lasts fewer than FILT_N clock edges is filtered out; core_rst stays 0.
- R4: Whenever core_rst is 1: rst_ind_n is 0, and hold_cancel, pin_tristate and cfg_pullup_en are 1. When core_rst is 0, all four take the opposite values, and rst_ind_n rises in the same cycle that core_rst falls.
- R5: bus_abort is high for exactly one cycle on each entry into the reset state, in the first cycle of the new reset; otherwise it is 0.
- R6: With external boot (boot_ext=1, sampled as the filtered pin releases), core_rst falls right after the (FILT_N+3+D)-th edge from the first edge that samples the pin high. D is max(dly_cfg+1, 3), so dly_cfg 0, 1 and 2 give 3, and dly_cfg 7 gives 8.
- R7: With internal boot (boot_ext=0), core_rst stays 1 after the pin is released until flash_init_done is seen high at an edge; core_rst falls right after that edge. flash_init_done is ignored while the pin still holds the block in reset.
- R8: flash_ovr_en is 1 from reset entry until flash_init_done is taken after release. flash_ovr_data is 16'hFFFF for the first EARLY_CYC edges after the release edge (release edge = FILT_N+3 edges after the pin rises), 16'h009B afterwards, and 16'h0000 when the override is off.
- R9: cfg_word captures cfg_port_in at the edge where core_rst falls and holds that value while the system runs.
- R10: A qualifying reset that arrives during a release wait restarts the sequence: core_rst stays 1, bus_abort pulses again, and the full release delay applies after the next release.
- R11: While the synchronous rst is high and just after it falls, the block is in the reset state: core_rst=1, rst_ind_n=0, bus_abort=0, flash_ovr_en=1, flash_ovr_data=16'hFFFF and cfg_word=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_rst_n | input | 1 | External reset pin, active low |
| rst_qual_n | input | 1 | Reset qualifier pin, active low |
| boot_ext | input | 1 | Boot strap: 1 external memory, 0 internal flash |
| dly_cfg | input | 3 | External-boot release delay setting |
| flash_init_done | input | 1 | Flash initialiser completion flag |
| cfg_port_in | input | CFG_W | Configuration port pins |
| core_rst | output | 1 | Internal core reset, active high |
| rst_ind_n | output | 1 | Reset indication, active low |
| hold_cancel | output | 1 | Cancel pending hold requests |
| bus_abort | output | 1 | One-cycle abort of bus cycles |
| pin_tristate | output | 1 | High-impedance enable for pin drivers |
| cfg_pullup_en | output | 1 | Weak pull-up on configuration port |
| cfg_word | output | CFG_W | Configuration word latched at release |
| flash_ovr_en | output | 1 | Flash read override active |
| flash_ovr_data | output | 16 | Placeholder word for flash reads |

## Verification
Entry to reset is due FILT_N+3 edges after the first sampling edge. The release of an external-boot reset is due FILT_N+3+D edges after the pin rises. The release of an internal-boot reset is due one edge after the completion flag. The placeholder word switches FILT_N+3+EARLY_CYC edges after the pin rises. The bench drives every input on a falling edge and counts rising edges from that point. It samples each output on the falling edge one cycle before its due edge, where the old value must still hold, and again one cycle later, where the new value must appear, so an early or late transition is reported. The bus-abort pulse is sampled in the cycle it is due and in the cycle after it.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD       = 2'd0,
        ST_EXT_WAIT   = 2'd1,
        ST_FLASH_WAIT = 2'd2,
        ST_RUN        = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic core_rst;
        logic hold_cancel;
        logic pin_tristate;
        logic cfg_pullup;
    } rst_ctl_t;

    localparam int          DLY_W        = 4;
    localparam logic [15:0] WORD_EARLY   = 16'hFFFF;
    localparam logic [15:0] WORD_LATE    = 16'h009B;
    localparam logic [15:0] WORD_IDLE    = 16'h0000;
    localparam logic [DLY_W-1:0] DLY_MIN = 4'd3;

    // Release delay in clocks: setting plus one, never below three.
    function automatic logic [DLY_W-1:0] release_delay(input logic [2:0] cfg);
        logic [DLY_W-1:0] d;
        d = {1'b0, cfg} + 4'd1;
        return (d < DLY_MIN) ? DLY_MIN : d;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RST_VAL;
                else     chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_glitch_filter.sv
module rstseq_glitch_filter #(
    parameter int   FILT_N = 4,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_N < 2) ? 1 : $clog2(FILT_N);
    localparam logic [CW-1:0] LAST = CW'(FILT_N - 1);

    logic [CW-1:0] run_q;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= INIT;
            run_q <= '0;
        end else if (din != lvl_q) begin
            if (run_q == LAST) begin
                lvl_q <= din;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign dout = lvl_q;

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_q <= LAST);                                                   // R3
    AST_FLIP_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(din)));               // R3
endmodule

// File: rtl/rstseq_release_ctrl.sv
module rstseq_release_ctrl
    import rstseq_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_asserted,
    input  logic             qual_low,
    input  logic             boot_ext,
    input  logic [2:0]       dly_cfg,
    input  logic             flash_init_done,
    input  logic [CFG_W-1:0] cfg_port_in,
    output rst_ctl_t         ctl,
    output logic             rst_ind_n,
    output logic             bus_abort,
    output logic [CFG_W-1:0] cfg_word,
    output logic             in_hold,
    output logic             hold_next
);
    seq_state_e       state_q, state_d;
    logic [DLY_W-1:0] wait_q;
    logic [DLY_W-1:0] dly_q;
    logic             abort_q;
    logic [CFG_W-1:0] cfg_q;
    logic             entry;

    assign entry = pin_asserted & qual_low;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:       if (!pin_asserted)
                               state_d = boot_ext ? ST_EXT_WAIT : ST_FLASH_WAIT;
            ST_EXT_WAIT:   if (wait_q == dly_q - 4'd1) state_d = ST_RUN;
            ST_FLASH_WAIT: if (flash_init_done)        state_d = ST_RUN;
            default:       state_d = ST_RUN;
        endcase
        if (entry) state_d = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            wait_q  <= '0;
            dly_q   <= DLY_MIN;
            abort_q <= 1'b0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            abort_q <= (state_q != ST_HOLD) && (state_d == ST_HOLD);
            if (state_q == ST_HOLD) begin
                wait_q <= '0;
                dly_q  <= release_delay(dly_cfg);
            end else if (state_q == ST_EXT_WAIT) begin
                wait_q <= wait_q + 1'b1;
            end
            if (state_d == ST_RUN && state_q != ST_RUN)
                cfg_q <= cfg_port_in;
        end
    end

    always_comb begin
        ctl.core_rst     = (state_q != ST_RUN);
        ctl.hold_cancel  = (state_q != ST_RUN);
        ctl.pin_tristate = (state_q != ST_RUN);
        ctl.cfg_pullup   = (state_q != ST_RUN);
    end

    assign rst_ind_n = (state_q == ST_RUN);
    assign bus_abort = abort_q;
    assign cfg_word  = cfg_q;
    assign in_hold   = (state_q == ST_HOLD);
    assign hold_next = (state_d == ST_HOLD);

    AST_EXT_DLY_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXT_WAIT) |-> (wait_q < dly_q) && (dly_q >= DLY_MIN)); // R6
    AST_INT_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_FLASH_WAIT)
            |-> $past(flash_init_done));                                  // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> $stable(cfg_q)); // R9
    AST_ENTRY_FROM_PINS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && $past(state_q) != ST_HOLD)
            |-> $past(pin_asserted && qual_low));                         // R1
endmodule

// File: rtl/rstseq_flash_guard.sv
module rstseq_flash_guard
    import rstseq_pkg::*;
#(
    parameter int EARLY_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_hold,
    input  logic        hold_next,
    input  logic        flash_init_done,
    output logic        ovr_en,
    output logic [15:0] ovr_data
);
    localparam int CW = $clog2(EARLY_CYC + 1);
    localparam logic [CW-1:0] EARLY_LIM = CW'(EARLY_CYC);

    logic          ready_q;
    logic [CW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            age_q   <= '0;
        end else if (hold_next) begin
            ready_q <= 1'b0;
            age_q   <= '0;
        end else if (!in_hold) begin
            if (flash_init_done) ready_q <= 1'b1;
            if (!ready_q && age_q < EARLY_LIM) age_q <= age_q + 1'b1;
        end
    end

    assign ovr_en   = !ready_q;
    assign ovr_data = ready_q           ? WORD_IDLE  :
                      (age_q < EARLY_LIM) ? WORD_EARLY : WORD_LATE;

    AST_OVR_WORDS: assert property (@(posedge clk) disable iff (rst)
        ovr_en |-> (ovr_data == WORD_EARLY || ovr_data == WORD_LATE));    // R8
    AST_PHASE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && !in_hold && !$past(in_hold) && $past(ovr_data) == WORD_LATE)
            |-> (ovr_data == WORD_LATE));                                 // R8
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        in_hold |-> ovr_en);                                              // R8
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
    import rstseq_pkg::*;
#(
    parameter int FILT_N      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int EARLY_CYC   = 16,
    parameter int CFG_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_rst_n,
    input  logic             rst_qual_n,
    input  logic             boot_ext,
    input  logic [2:0]       dly_cfg,
    input  logic             flash_init_done,
    input  logic [CFG_W-1:0] cfg_port_in,
    output logic             core_rst,
    output logic             rst_ind_n,
    output logic             hold_cancel,
    output logic             bus_abort,
    output logic             pin_tristate,
    output logic             cfg_pullup_en,
    output logic [CFG_W-1:0] cfg_word,
    output logic             flash_ovr_en,
    output logic [15:0]      flash_ovr_data
);
    logic     pin_lo_s, qual_lo_s, pin_lo_f;
    logic     in_hold, hold_next;
    rst_ctl_t ctl;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst(rst), .din(~ext_rst_n), .dout(pin_lo_s));

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_qual_sync (
        .clk(clk), .rst(rst), .din(~rst_qual_n), .dout(qual_lo_s));

    rstseq_glitch_filter #(.FILT_N(FILT_N), .INIT(1'b1)) u_filt (
        .clk(clk), .rst(rst), .din(pin_lo_s), .dout(pin_lo_f));

    rstseq_release_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .pin_asserted(pin_lo_f), .qual_low(qual_lo_s),
        .boot_ext(boot_ext), .dly_cfg(dly_cfg),
        .flash_init_done(flash_init_done), .cfg_port_in(cfg_port_in),
        .ctl(ctl), .rst_ind_n(rst_ind_n), .bus_abort(bus_abort),
        .cfg_word(cfg_word), .in_hold(in_hold), .hold_next(hold_next));

    rstseq_flash_guard #(.EARLY_CYC(EARLY_CYC)) u_guard (
        .clk(clk), .rst(rst), .in_hold(in_hold), .hold_next(hold_next),
        .flash_init_done(flash_init_done),
        .ovr_en(flash_ovr_en), .ovr_data(flash_ovr_data));

    assign core_rst      = ctl.core_rst;
    assign hold_cancel   = ctl.hold_cancel;
    assign pin_tristate  = ctl.pin_tristate;
    assign cfg_pullup_en = ctl.cfg_pullup;

    AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (in_hold && !$past(in_hold)) |-> bus_abort);                      // R5
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_abort |=> !bus_abort);                                        // R5
    AST_RESET_PINS: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (!rst_ind_n && pin_tristate && hold_cancel));        // R4
    AST_RUN_NEEDS_FLASH: assert property (@(posedge clk) disable iff (rst)
        in_hold |-> core_rst && flash_ovr_en);                            // R8
endmodule

// File: tb/boot_reset_seq_test.sv
`timescale 1ns/1ps
module boot_reset_seq_test;
    localparam int N     = 4;
    localparam int EARLY = 16;
    localparam int ROWS  = 5;
    // [15:12] dly_cfg, [11:8] expected release delay D, [7:0] config port value
    localparam logic [15:0] VEC [ROWS] = '{16'h03A5, 16'h233C, 16'h3481,
                                           16'h5666, 16'h78F0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_rst_n = 1'b0, rst_qual_n = 1'b0, boot_ext = 1'b1;
    logic [2:0] dly_cfg = 3'd5;
    logic flash_init_done = 1'b0;
    logic [7:0] cfg_port_in = 8'h00;
    logic core_rst, rst_ind_n, hold_cancel, bus_abort, pin_tristate, cfg_pullup_en;
    logic [7:0] cfg_word;
    logic flash_ovr_en;
    logic [15:0] flash_ovr_data;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    boot_reset_seq #(.FILT_N(N), .SYNC_STAGES(2), .EARLY_CYC(EARLY), .CFG_W(8)) uut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .rst_qual_n(rst_qual_n),
        .boot_ext(boot_ext), .dly_cfg(dly_cfg), .flash_init_done(flash_init_done),
        .cfg_port_in(cfg_port_in), .core_rst(core_rst), .rst_ind_n(rst_ind_n),
        .hold_cancel(hold_cancel), .bus_abort(bus_abort), .pin_tristate(pin_tristate),
        .cfg_pullup_en(cfg_pullup_en), .cfg_word(cfg_word),
        .flash_ovr_en(flash_ovr_en), .flash_ovr_data(flash_ovr_data));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_reset_pins(input string req, input logic in_rst);
        chk(req, core_rst, in_rst);
        chk(req, rst_ind_n, !in_rst);
        chk(req, hold_cancel, in_rst);
        chk(req, pin_tristate, in_rst);
        chk(req, cfg_pullup_en, in_rst);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        wait_cyc(3);
        // R11: reset state while rst high
        chk("R11", core_rst, 1);
        chk("R11", rst_ind_n, 0);
        chk("R11", bus_abort, 0);
        chk("R11", flash_ovr_en, 1);
        chk("R11", flash_ovr_data, 32'hFFFF);
        chk("R11", cfg_word, 0);
        rst = 1'b0;
        wait_cyc(3);
        chk("R11", core_rst, 1);

        // Table: external-boot release delays, config capture, re-entry timing
        for (int i = 0; i < ROWS; i++) begin
            dly_cfg     = VEC[i][14:12];
            cfg_port_in = VEC[i][7:0];
            boot_ext    = 1'b1;
            ext_rst_n   = 1'b1;
            rst_qual_n  = 1'b1;
            wait_cyc(N + 2 + int'(VEC[i][11:8]));
            chk("R6", core_rst, 1);
            chk_reset_pins("R4", 1'b1);
            wait_cyc(1);
            chk("R6", core_rst, 0);
            chk_reset_pins("R4", 1'b0);
            chk("R9", cfg_word, VEC[i][7:0]);
            cfg_port_in = ~VEC[i][7:0];
            wait_cyc(4);
            chk("R9", cfg_word, VEC[i][7:0]);
            ext_rst_n  = 1'b0;
            rst_qual_n = 1'b0;
            wait_cyc(N + 2);
            chk("R1", core_rst, 0);
            chk("R5", bus_abort, 0);
            wait_cyc(1);
            chk("R1", core_rst, 1);
            chk("R5", bus_abort, 1);
            wait_cyc(1);
            chk("R5", bus_abort, 0);
        end

        // Release into run for the ignore tests
        dly_cfg = 3'd0; boot_ext = 1'b1; cfg_port_in = 8'h5A;
        ext_rst_n = 1'b1; rst_qual_n = 1'b1;
        wait_cyc(N + 6);
        chk("R6", core_rst, 0);

        // R2: reset pin low while qualifier high has no effect
        ext_rst_n = 1'b0;
        wait_cyc(20);
        chk("R2", core_rst, 0);
        chk("R2", bus_abort, 0);
        ext_rst_n = 1'b1;
        wait_cyc(N + 4);

        // R3: pulse shorter than the filter is ignored
        ext_rst_n = 1'b0; rst_qual_n = 1'b0;
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        ext_rst_n = 1'b1; rst_qual_n = 1'b1;
        wait_cyc(20);
        chk("R3", core_rst, 0);
        chk("R3", cfg_word, 32'h5A);

        // R10: new reset during the external release wait restarts it
        ext_rst_n = 1'b0; rst_qual_n = 1'b0;
        wait_cyc(N + 4);
        chk("R10", core_rst, 1);
        dly_cfg = 3'd7;
        ext_rst_n = 1'b1; rst_qual_n = 1'b1;
        wait_cyc(4);
        ext_rst_n = 1'b0; rst_qual_n = 1'b0;
        wait_cyc(N + 2);
        chk("R10", core_rst, 1);
        chk("R10", bus_abort, 0);
        wait_cyc(1);
        chk("R10", bus_abort, 1);
        chk("R10", core_rst, 1);
        wait_cyc(6);
        ext_rst_n = 1'b1; rst_qual_n = 1'b1;
        wait_cyc(N + 2 + 8);
        chk("R10", core_rst, 1);
        wait_cyc(1);
        chk("R10", core_rst, 0);

        // R7 / R8: internal boot waits for flash completion
        ext_rst_n = 1'b0; rst_qual_n = 1'b0;
        wait_cyc(N + 4);
        boot_ext = 1'b0;
        flash_init_done = 1'b1;
        wait_cyc(4);
        chk("R7", core_rst, 1);
        chk("R8", flash_ovr_en, 1);
        chk("R8", flash_ovr_data, 32'hFFFF);
        flash_init_done = 1'b0;
        ext_rst_n = 1'b1; rst_qual_n = 1'b1;
        wait_cyc(N + 2 + EARLY);
        chk("R8", flash_ovr_en, 1);
        chk("R8", flash_ovr_data, 32'hFFFF);
        wait_cyc(1);
        chk("R8", flash_ovr_data, 32'h009B);
        wait_cyc(30);
        chk("R7", core_rst, 1);
        chk("R8", flash_ovr_data, 32'h009B);
        cfg_port_in = 8'hC3;
        flash_init_done = 1'b1;
        wait_cyc(1);
        chk("R7", core_rst, 0);
        chk("R4", rst_ind_n, 1);
        chk("R8", flash_ovr_en, 0);
        chk("R8", flash_ovr_data, 32'h0000);
        chk("R9", cfg_word, 32'hC3);
        flash_init_done = 1'b0;
        wait_cyc(3);
        chk("R8", flash_ovr_en, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule